// File: doc/BRIEF.md
# I2C Target with Optional Clock Stretching

This block is the target side of a two-wire serial bus. It watches the clock and data lines through synchronisers, which run on the system clock. It drives each line only through an open-drain pull-down enable, so the block either pulls a line low or leaves it released. The block recognises start, repeated start and stop conditions. It then takes in a 7-bit address followed by a direction bit, and acknowledges only the address set by a parameter. After that it moves data bytes one at a time, each byte followed by an acknowledge slot.

Local logic connects through a byte interface:
- A one-cycle strobe presents each received byte.
- A one-cycle request asks for the next byte to send.
- A ready input says whether the local side can go on.

When the stretch-enable input is high and the local side is not ready at a byte boundary, the block holds the clock line low until ready returns. When stretching is off, the block never touches the clock line and the transfer goes on at the controller's pace.

The controller lives in one enumerated state machine. The states are listed below.

| State | Role |
|---|---|
| IDLE | Bus free; waiting for a start. |
| ADDR | Shifting in the address and direction bits. |
| ADDR_ACK | Pulling SDA low in the ninth slot after a matching address. |
| WR_BYTE | Shifting in a data byte. |
| WR_ACK | Acknowledging a received byte. |
| WR_HOLD | Stretching before a write byte. |
| RD_HOLD | Stretching before a read byte. |
| RD_BYTE | Shifting a byte out. |
| RD_ACK | Sampling the controller's acknowledge. |
| SKIP | Not addressed, or the read has ended; waiting for a start or stop. |

The transitions are these:
- A stop condition moves any state to IDLE.
- A start condition moves any state to ADDR.
- ADDR goes to ADDR_ACK when the address matches and to SKIP when it does not. The decision is taken on the SCL falling edge after the eighth bit.
- ADDR_ACK and WR_ACK go to a byte state, or to its HOLD state, on the SCL falling edge that ends the slot.
- WR_HOLD goes to WR_BYTE, and RD_HOLD goes to RD_BYTE, once ready is high or stretching is off.
- WR_BYTE goes to WR_ACK, and RD_BYTE goes to RD_ACK, on the falling edge that ends the eighth bit.
- RD_ACK goes to RD_BYTE or RD_HOLD when the controller acknowledged, and to SKIP when it did not.

Top module: `i2c_tgt_stretch`

## Requirements
- R1: After reset, both pull-down enables are low and neither the receive strobe nor the transmit request is asserted.
- R2: A start (SDA falls while SCL is high) begins address reception. After a stop (SDA rises while SCL is high), bits clocked without a new start are ignored and get no acknowledge.
- R3: The first byte after a start holds the address, MSB first, in its upper 7 bits, with the direction in bit 0 (1 = read). Only the block's own address gets SDA held low in the ninth slot. Any other address is left unacknowledged, and the block ignores the bus until the next start.
- R4: In a write, each data byte is taken in MSB first on SCL rising edges. It appears on rx_data_o together with a one-cycle rx_valid_o pulse after the eighth bit.
- R5: Every byte the block receives in a write is acknowledged in its ninth slot.
- R6: In a read, the block captures tx_data_i when it starts a byte: at the end of the previous acknowledge slot, or when a stretch ends. It shifts that byte out MSB first and pulses tx_req_o one cycle after the capture.
- R7: A not-acknowledge from the controller after a read byte ends the read. SDA stays released, and no further byte is requested, until the next start.
- R8: A repeated start with no stop before it restarts address reception, including a change of direction.
- R9: With stretch_en_i high, when local_rdy_i is low at a byte boundary, SCL is held low until local_rdy_i is seen high. SCL is released on the following cycle, and the transfer then completes normally.
- R10: With stretch_en_i low, scl_oe_o is never asserted, and transfers complete whatever the state of local_rdy_i.
- R11: The SDA pull-down changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stretch_en_i | input | 1 | Allows the block to hold SCL low |
| scl_i | input | 1 | Sensed clock line |
| sda_i | input | 1 | Sensed data line |
| scl_oe_o | output | 1 | Pulls SCL low when high |
| sda_oe_o | output | 1 | Pulls SDA low when high |
| local_rdy_i | input | 1 | Local side can accept or supply the next byte |
| rx_valid_o | output | 1 | One-cycle strobe: rx_data_o holds a received byte |
| rx_data_o | output | 8 | Last received data byte |
| tx_data_i | input | 8 | Next byte to transmit |
| tx_req_o | output | 1 | One-cycle pulse: tx_data_i was taken, present the next |

## Verification
Several decisions can fall at the same SCL falling edge:
- the end of an acknowledge slot;
- the stretch decision, which samples local_rdy_i;
- the capture of the transmit byte.

The directed tests cover two arrangements. In one, ready is low when a byte boundary arrives and is raised while SCL is held. In the other, ready is low with stretching disabled, so the capture must happen at once. The repeated-start scenario places a start right after a data bit has been counted, so start detection and bit shifting fall in the same window. The bench judges that case by the acknowledge of the new address and by the read data that follows.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_WR_HOLD,
        ST_RD_HOLD,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_SKIP
    } tgt_state_e;

endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic q,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '1;
                else        chain <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b1;
        else        prev <= chain[STAGES-1];
    end

    assign q    = chain[STAGES-1];
    assign rise = chain[STAGES-1] & ~prev;
    assign fall = ~chain[STAGES-1] & prev;

endmodule

// File: rtl/i2ct_cond_det.sv
module i2ct_cond_det (
    input  logic scl_s,
    input  logic sda_rise,
    input  logic sda_fall,
    output logic start,
    output logic stop
);
    // Bus conditions are SDA edges while the clock line rests high.
    assign start = sda_fall & scl_s;
    assign stop  = sda_rise & scl_s;
endmodule

// File: rtl/i2ct_fsm.sv
module i2ct_fsm
    import i2ct_pkg::*;
#(
    parameter int                 BYTE_W   = 8,
    parameter logic [BYTE_W-2:0]  TGT_ADDR = 7'h3A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stretch_en,
    input  logic              local_rdy,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_s,
    input  logic              start,
    input  logic              stop,
    output logic              sda_oe,
    output logic              scl_oe,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_data,
    output logic              tx_req
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    tgt_state_e        st, nxt;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic              rw_q;
    logic              mack_q;
    logic              go;
    logic              addr_hit;

    assign go       = local_rdy | ~stretch_en;
    assign addr_hit = (rx_sh[BYTE_W-1:1] == TGT_ADDR);

    // Next-state decision
    always_comb begin
        nxt = st;
        if (stop) begin
            nxt = ST_IDLE;
        end else if (start) begin
            nxt = ST_ADDR;
        end else begin
            unique case (st)
                ST_IDLE:     nxt = ST_IDLE;
                ST_SKIP:     nxt = ST_SKIP;
                ST_ADDR:
                    if (scl_fall && cnt == CNT_FULL)
                        nxt = addr_hit ? ST_ADDR_ACK : ST_SKIP;
                ST_ADDR_ACK:
                    if (scl_fall) begin
                        if (rw_q) nxt = go ? ST_RD_BYTE : ST_RD_HOLD;
                        else      nxt = go ? ST_WR_BYTE : ST_WR_HOLD;
                    end
                ST_WR_BYTE:
                    if (scl_fall && cnt == CNT_FULL) nxt = ST_WR_ACK;
                ST_WR_ACK:
                    if (scl_fall) nxt = go ? ST_WR_BYTE : ST_WR_HOLD;
                ST_WR_HOLD:
                    if (go) nxt = ST_WR_BYTE;
                ST_RD_HOLD:
                    if (go) nxt = ST_RD_BYTE;
                ST_RD_BYTE:
                    if (scl_fall && cnt == CNT_LAST) nxt = ST_RD_ACK;
                ST_RD_ACK:
                    if (scl_fall) begin
                        if (mack_q) nxt = go ? ST_RD_BYTE : ST_RD_HOLD;
                        else        nxt = ST_SKIP;
                    end
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // Shift registers, bit counter and local-side strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            rx_sh    <= '0;
            tx_sh    <= '1;
            rw_q     <= 1'b0;
            mack_q   <= 1'b0;
            rx_valid <= 1'b0;
            rx_data  <= '0;
            tx_req   <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            tx_req   <= 1'b0;

            if ((st == ST_ADDR || st == ST_WR_BYTE) && scl_rise && cnt < CNT_FULL) begin
                rx_sh <= {rx_sh[BYTE_W-2:0], sda_s};
                cnt   <= cnt + 1'b1;
                if (st == ST_WR_BYTE && cnt == CNT_LAST) begin
                    rx_valid <= 1'b1;
                    rx_data  <= {rx_sh[BYTE_W-2:0], sda_s};
                end
            end

            if (st == ST_ADDR && scl_fall && cnt == CNT_FULL)
                rw_q <= rx_sh[0];

            if (st == ST_RD_BYTE && scl_fall && cnt != CNT_LAST) begin
                tx_sh <= {tx_sh[BYTE_W-2:0], 1'b1};
                cnt   <= cnt + 1'b1;
            end

            if (st == ST_RD_ACK && scl_rise)
                mack_q <= ~sda_s;

            if (nxt == ST_RD_BYTE && st != ST_RD_BYTE) begin
                tx_sh  <= tx_data;
                cnt    <= '0;
                tx_req <= 1'b1;
            end

            if (nxt == ST_WR_BYTE && st != ST_WR_BYTE)
                cnt <= '0;

            if (start)
                cnt <= '0;
        end
    end

    // Outputs
    always_comb begin
        sda_oe = 1'b0;
        scl_oe = 1'b0;
        unique case (st)
            ST_ADDR_ACK, ST_WR_ACK: sda_oe = 1'b1;
            ST_RD_BYTE:             sda_oe = ~tx_sh[BYTE_W-1];
            ST_WR_HOLD, ST_RD_HOLD: scl_oe = stretch_en;
            default: ;
        endcase
    end

    // R9
    stretch_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_oe) |-> $past(stretch_en && !local_rdy));

    // R9
    stretch_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_oe && local_rdy) |=> !scl_oe);

    // R4
    rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R6
    tx_req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |=> !tx_req);

endmodule

// File: rtl/i2c_tgt_stretch.sv
module i2c_tgt_stretch #(
    parameter int          BYTE_W      = 8,
    parameter int          SYNC_STAGES = 2,
    parameter logic [6:0]  TGT_ADDR    = 7'h3A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stretch_en_i,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe_o,
    output logic              sda_oe_o,
    input  logic              local_rdy_i,
    output logic              rx_valid_o,
    output logic [BYTE_W-1:0] rx_data_o,
    input  logic [BYTE_W-1:0] tx_data_i,
    output logic              tx_req_o
);
    logic scl_s, scl_rise, scl_fall;
    logic sda_s, sda_rise, sda_fall;
    logic start, stop;

    i2ct_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (scl_i),
        .q    (scl_s),
        .rise (scl_rise),
        .fall (scl_fall)
    );

    i2ct_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (sda_i),
        .q    (sda_s),
        .rise (sda_rise),
        .fall (sda_fall)
    );

    i2ct_cond_det u_cond (
        .scl_s   (scl_s),
        .sda_rise(sda_rise),
        .sda_fall(sda_fall),
        .start   (start),
        .stop    (stop)
    );

    i2ct_fsm #(.BYTE_W(BYTE_W), .TGT_ADDR(TGT_ADDR)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .stretch_en(stretch_en_i),
        .local_rdy (local_rdy_i),
        .tx_data   (tx_data_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_s     (sda_s),
        .start     (start),
        .stop      (stop),
        .sda_oe    (sda_oe_o),
        .scl_oe    (scl_oe_o),
        .rx_valid  (rx_valid_o),
        .rx_data   (rx_data_o),
        .tx_req    (tx_req_o)
    );

    // R10
    no_scl_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stretch_en_i |-> !scl_oe_o);

    // R11
    sda_move_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_s);

endmodule

// File: tb/i2c_tgt_stretch_tb_top.sv
module i2c_tgt_stretch_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 6;
    localparam logic [6:0] MY_ADDR = 7'h3A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stretch_en = 1'b1;
    logic local_rdy  = 1'b1;
    logic scl_c = 1'b1;
    logic sda_c = 1'b1;
    logic scl_oe, sda_oe, rx_valid, tx_req;
    logic [7:0] rx_data, tx_data;
    wire scl_w = scl_c & ~scl_oe;
    wire sda_w = sda_c & ~sda_oe;

    int checks = 0;
    int fails  = 0;
    int rx_cnt = 0;
    int txq_cnt = 0;
    int scl_oe_cyc = 0;
    logic [7:0] rx_last = 8'h00;
    logic [2:0] tx_idx = 3'd0;
    logic [7:0] tx_mem [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign tx_data = tx_mem[tx_idx];

    i2c_tgt_stretch dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .stretch_en_i(stretch_en),
        .scl_i       (scl_w),
        .sda_i       (sda_w),
        .scl_oe_o    (scl_oe),
        .sda_oe_o    (sda_oe),
        .local_rdy_i (local_rdy),
        .rx_valid_o  (rx_valid),
        .rx_data_o   (rx_data),
        .tx_data_i   (tx_data),
        .tx_req_o    (tx_req)
    );

    // Local-side model
    always @(negedge clk) begin
        if (rx_valid) begin rx_last <= rx_data; rx_cnt <= rx_cnt + 1; end
        if (tx_req)   begin tx_idx <= tx_idx + 3'd1; txq_cnt <= txq_cnt + 1; end
        if (scl_oe)   scl_oe_cyc <= scl_oe_cyc + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic scl_up();
        scl_c = 1'b1;
        while (!scl_w) @(negedge clk);
        wclk(Q);
    endtask

    task automatic c_start();
        sda_c = 1'b1; wclk(Q);
        scl_up();
        sda_c = 1'b0; wclk(Q);
        scl_c = 1'b0; wclk(Q);
    endtask

    task automatic c_stop();
        sda_c = 1'b0; wclk(Q);
        scl_up();
        sda_c = 1'b1; wclk(Q);
    endtask

    task automatic c_bit(input logic b, output logic r);
        sda_c = b; wclk(Q);
        scl_up();
        r = sda_w;
        scl_c = 1'b0; wclk(Q);
    endtask

    task automatic wr_byte(input logic [7:0] d, output logic acked);
        logic r;
        for (int i = 7; i >= 0; i--) c_bit(d[i], r);
        c_bit(1'b1, r);
        acked = ~r;
    endtask

    task automatic rd_byte(output logic [7:0] d, input logic give_ack);
        logic r;
        for (int i = 7; i >= 0; i--) begin c_bit(1'b1, r); d[i] = r; end
        c_bit(~give_ack, r);
    endtask

    task automatic t_reset();
        wclk(3);
        chk("R1 sda_oe", sda_oe, 0);
        chk("R1 scl_oe", scl_oe, 0);
        chk("R1 rx_valid", rx_valid, 0);
        chk("R1 tx_req", tx_req, 0);
    endtask

    task automatic t_write();
        logic a; int n0;
        n0 = rx_cnt;
        c_start();
        wr_byte({MY_ADDR, 1'b0}, a); chk("R3 own address acked", a, 1);
        wr_byte(8'h96, a);           chk("R5 byte0 acked", a, 1);
        chk("R4 byte0 data", rx_last, 8'h96);
        wr_byte(8'h2D, a);           chk("R5 byte1 acked", a, 1);
        chk("R4 byte1 data", rx_last, 8'h2D);
        chk("R4 strobe count", rx_cnt - n0, 2);
        c_stop();
    endtask

    task automatic t_bad_addr();
        logic a; int n0;
        n0 = rx_cnt;
        c_start();
        wr_byte({MY_ADDR ^ 7'h01, 1'b0}, a); chk("R3 foreign address nacked", a, 0);
        wr_byte(8'h00, a);                   chk("R3 data after foreign address nacked", a, 0);
        chk("R3 no byte delivered", rx_cnt - n0, 0);
        c_stop();
    endtask

    task automatic t_read_nack();
        logic a; logic [7:0] d; logic [7:0] e0, e1; int q0;
        e0 = tx_mem[tx_idx]; e1 = tx_mem[tx_idx + 3'd1]; q0 = txq_cnt;
        c_start();
        wr_byte({MY_ADDR, 1'b1}, a); chk("R3 read address acked", a, 1);
        rd_byte(d, 1'b1); chk("R6 read byte0", d, e0);
        rd_byte(d, 1'b0); chk("R6 read byte1", d, e1);
        chk("R6 two requests", txq_cnt - q0, 2);
        rd_byte(d, 1'b0); chk("R7 SDA released after nack", d, 8'hFF);
        chk("R7 no request after nack", txq_cnt - q0, 2);
        c_stop();
    endtask

    task automatic t_rep_start();
        logic a; logic [7:0] d; logic [7:0] e;
        c_start();
        wr_byte({MY_ADDR, 1'b0}, a); chk("R8 write address acked", a, 1);
        wr_byte(8'h11, a);           chk("R8 write data acked", a, 1);
        chk("R8 write data", rx_last, 8'h11);
        e = tx_mem[tx_idx];
        c_start();
        wr_byte({MY_ADDR, 1'b1}, a); chk("R8 address after repeated start acked", a, 1);
        rd_byte(d, 1'b0);            chk("R8 read after repeated start", d, e);
        c_stop();
    endtask

    task automatic t_stretch_wr();
        logic a; int n0;
        stretch_en = 1'b1; local_rdy = 1'b0; n0 = rx_cnt;
        c_start();
        wr_byte({MY_ADDR, 1'b0}, a); chk("R3 stretch write address acked", a, 1);
        fork
            wr_byte(8'h5C, a);
            begin
                wclk(40);
                chk("R9 SCL held during write hold", scl_oe, 1);
                chk("R9 no byte while held", rx_cnt - n0, 0);
                local_rdy = 1'b1;
                wclk(2);
                chk("R9 SCL released after ready", scl_oe, 0);
            end
        join
        chk("R9 byte acked after stretch", a, 1);
        chk("R9 byte delivered after stretch", rx_last, 8'h5C);
        c_stop();
    endtask

    task automatic t_stretch_rd();
        logic a; logic [7:0] d; logic [7:0] e; int q0;
        stretch_en = 1'b1; local_rdy = 1'b0; q0 = txq_cnt;
        c_start();
        wr_byte({MY_ADDR, 1'b1}, a); chk("R3 stretch read address acked", a, 1);
        fork
            rd_byte(d, 1'b0);
            begin
                wclk(40);
                chk("R9 SCL held during read hold", scl_oe, 1);
                chk("R6 no capture while held", txq_cnt - q0, 0);
                tx_mem[tx_idx] = 8'hE7;
                e = 8'hE7;
                local_rdy = 1'b1;
            end
        join
        chk("R6 byte captured at hold release", d, e);
        c_stop();
    endtask

    task automatic t_no_stretch();
        logic a; logic [7:0] d; logic [7:0] e;
        stretch_en = 1'b0; local_rdy = 1'b0;
        scl_oe_cyc = 0;
        c_start();
        wr_byte({MY_ADDR, 1'b0}, a); chk("R10 address acked", a, 1);
        wr_byte(8'hB4, a);           chk("R10 write completes", rx_last, 8'hB4);
        e = tx_mem[tx_idx];
        c_start();
        wr_byte({MY_ADDR, 1'b1}, a);
        rd_byte(d, 1'b0);            chk("R10 read completes", d, e);
        c_stop();
        chk("R10 SCL never driven", scl_oe_cyc, 0);
        stretch_en = 1'b1; local_rdy = 1'b1;
    endtask

    task automatic t_after_stop();
        logic r; logic [7:0] b; int n0;
        b = {MY_ADDR, 1'b0}; n0 = rx_cnt;
        scl_c = 1'b0; wclk(Q);
        for (int i = 7; i >= 0; i--) c_bit(b[i], r);
        c_bit(1'b1, r);
        chk("R2 no ack without start", r, 1);
        for (int i = 7; i >= 0; i--) c_bit(1'b0, r);
        chk("R2 no byte without start", rx_cnt - n0, 0);
        sda_c = 1'b1; wclk(Q);
        scl_up();
    endtask

    initial begin
        tx_mem[0] = 8'hC3; tx_mem[1] = 8'h5A; tx_mem[2] = 8'h00; tx_mem[3] = 8'hFF;
        tx_mem[4] = 8'h81; tx_mem[5] = 8'h3C; tx_mem[6] = 8'h96; tx_mem[7] = 8'h69;
        wclk(4);
        rst_n = 1'b1;
        t_reset();
        t_write();
        t_bad_addr();
        t_read_nack();
        t_rep_start();
        t_stretch_wr();
        t_stretch_rd();
        t_no_stretch();
        t_after_stop();
        wclk(10);
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule